// File: doc/BRIEF.md
# Packed Word Bus-to-FIFO Adapter

This block sits between a 32-bit register interface and the transmit and receive FIFOs of one serial channel. Normally each bus write pushes one serial word into the transmit FIFO and each bus read pops one word from the receive FIFO. When packing is enabled and the configured word length is short enough, one 32-bit write is split into two or four serial words, and one 32-bit read gathers two or four popped words into a single bus word. Words are moved one per clock, lowest lane first, while `busy` is high.

The packing factor is chosen at run time from the word-length code. A packed access is accepted only if it is a full 32-bit access, the channel FIFO is enabled and the FIFO can take or supply all the words at once; otherwise the access is refused with a one-cycle error pulse. A sticky error flag records every violated packing precondition, including level thresholds that are not 32-bit aligned and an illegal word-count setting. A write-one strobe clears the flag.

Top module: `packed_word_bridge`

## Requirements
- R1: The word-length code `cfg_wlen` holds the serial word length minus one. Packing is in effect only when `cfg_pack_en`=1 and `cfg_wlen` ≤ 14. Codes 0–6 give 4 words per access, codes 7–14 give 2 words per access, and in every other case (including `cfg_pack_en`=0) each access moves 1 word.
- R2: In 4-word mode, word i uses bus bits 8i+7..8i. Bus bits above the word length inside a lane are dropped on writes and read back as zero.
- R3: In 2-word mode, word i uses bus bits 16i+15..16i, with the same masking as R2.
- R4: In 1-word mode, the word uses the whole bus word masked to `cfg_wlen`+1 bits (code 31 keeps all 32 bits), both on `tx_data` and on `bus_rdata`.
- R5: After the edge that accepts an access, `tx_push` (write) or `rx_pop` (read) is high for exactly N consecutive cycles, lane 0 first. `busy` is high in exactly those cycles. On a read, `bus_rvalid` pulses in the cycle after the last pop and `bus_rdata` holds the assembled word.
- R6: A write is refused when `tx_space` < N: `err_pulse` is high for one cycle after the request and nothing is pushed.
- R7: A read is refused when `rx_count` < N: `err_pulse` pulses and nothing is popped.
- R8: While packing is in effect, an access with `bus_full`=0 or with `cfg_fifo_en`=0 is refused (error pulse, no transfer) and sets `err_sticky`.
- R9: While packing is in effect, `err_sticky` is set if either threshold's two low bits are not 2'b11, if `cfg_fifo_en`=0, or if `cfg_wcount` is nonzero with bit 0 set (2-word mode) or with bit 0 or bit 1 set (4-word mode).
- R10: `err_sticky` stays set until an `err_clr` pulse. If a set condition is present in the same cycle, the set wins.
- R11: A request made while `busy` is high is ignored.
- R12: After reset, `busy`, `tx_push`, `rx_pop`, `bus_rvalid`, `err_pulse` and `err_sticky` are 0, and `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pack_en | input | 1 | Packing enable |
| cfg_fifo_en | input | 1 | Channel FIFO enabled |
| cfg_wlen | input | 5 | Word length minus one |
| cfg_ae_low2 | input | 2 | Two low bits of the almost-empty threshold |
| cfg_af_low2 | input | 2 | Two low bits of the almost-full threshold |
| cfg_wcount | input | 16 | Transfer word count (0 = not used) |
| err_clr | input | 1 | Write-one strobe that clears the sticky error |
| bus_wr | input | 1 | Bus write request (one cycle) |
| bus_rd | input | 1 | Bus read request (one cycle) |
| bus_full | input | 1 | 1 = full 32-bit access, 0 = narrower access |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Assembled read data |
| bus_rvalid | output | 1 | Read data valid pulse |
| busy | output | 1 | Transfer sequence in progress |
| err_pulse | output | 1 | Access refused (one cycle) |
| err_sticky | output | 1 | Sticky packing-rule violation flag |
| tx_space | input | 4 | Free entries in the transmit FIFO |
| tx_push | output | 1 | Push strobe to the transmit FIFO |
| tx_data | output | 32 | Word pushed to the transmit FIFO |
| rx_count | input | 4 | Entries held in the receive FIFO |
| rx_pop | output | 1 | Pop strobe to the receive FIFO |
| rx_data | input | 32 | Head word of the receive FIFO |

## Verification
The hardest case to reach is a request that arrives in the middle of a packed burst. The bus side only issues single-cycle requests, and a stray one has to land while the sequencer is still walking lanes. The stimulus gets there with a dedicated access that raises a second write with different data one cycle after a 4-word write is accepted. The test then checks that only the original four lane values reach the transmit side. Refusals at exact FIFO occupancy boundaries are also rare under plain random occupancy, so directed accesses set the free space and fill count just one below the packing factor.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  typedef enum logic [1:0] {
    PK_ONE  = 2'd0,
    PK_TWO  = 2'd1,
    PK_FOUR = 2'd2
  } pk_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WR   = 2'd1,
    SQ_RD   = 2'd2
  } sq_state_e;

  localparam int unsigned PK_MAX_WORDS = 4;
  localparam int unsigned PK_IDX_W     = $clog2(PK_MAX_WORDS);

  function automatic logic [2:0] pk_words(input pk_mode_e m);
    case (m)
      PK_FOUR: pk_words = 3'd4;
      PK_TWO:  pk_words = 3'd2;
      default: pk_words = 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/pwb_cfg_decode.sv
module pwb_cfg_decode
  import pwb_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int WL_W   = 5,
  parameter int WCNT_W = 16
) (
  input  logic              pack_en,
  input  logic              fifo_en,
  input  logic [WL_W-1:0]   wlen,
  input  logic [1:0]        ae_low2,
  input  logic [1:0]        af_low2,
  input  logic [WCNT_W-1:0] wcount,
  output pk_mode_e          mode,
  output logic              pack_on,
  output logic              cfg_fault,
  output logic [BUS_W-1:0]  len_mask
);

  localparam int GRAN_W   = BUS_W / PK_MAX_WORDS;
  localparam int FOUR_MAX = GRAN_W - 2;
  localparam int TWO_MAX  = 2 * GRAN_W - 2;
  localparam int IW       = $clog2(BUS_W) + 1;

  logic thr_bad;
  logic cnt_bad;
  logic cnt_used;

  always_comb begin
    mode = PK_ONE;
    if (pack_en) begin
      if (wlen <= WL_W'(FOUR_MAX))     mode = PK_FOUR;
      else if (wlen <= WL_W'(TWO_MAX)) mode = PK_TWO;
    end
  end

  assign pack_on  = (mode != PK_ONE);
  assign thr_bad  = (ae_low2 != 2'b11) | (af_low2 != 2'b11);
  assign cnt_used = |wcount;

  always_comb begin
    cnt_bad = 1'b0;
    if (cnt_used) begin
      case (mode)
        PK_TWO:  cnt_bad = wcount[0];
        PK_FOUR: cnt_bad = |wcount[1:0];
        default: cnt_bad = 1'b0;
      endcase
    end
  end

  assign cfg_fault = pack_on & (thr_bad | cnt_bad | ~fifo_en);

  for (genvar i = 0; i < BUS_W; i++) begin : g_mask
    assign len_mask[i] = (IW'(i) <= IW'(wlen));
  end

endmodule

// File: rtl/pwb_tx_unpack.sv
module pwb_tx_unpack
  import pwb_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BUS_W-1:0] ld_data,
  input  logic [BUS_W-1:0] ld_mask,
  input  pk_mode_e         ld_mode,
  input  logic             step,
  output logic [BUS_W-1:0] tx_data
);

  localparam int LANE4_W = BUS_W / 4;
  localparam int LANE2_W = BUS_W / 2;

  logic [BUS_W-1:0] sr_q, sr_n;
  logic [BUS_W-1:0] msk_q, msk_n;
  pk_mode_e         mode_q, mode_n;
  logic             reg_en;

  assign reg_en = load | step;

  always_comb begin
    sr_n   = sr_q;
    msk_n  = msk_q;
    mode_n = mode_q;
    if (load) begin
      sr_n   = ld_data;
      msk_n  = ld_mask;
      mode_n = ld_mode;
    end else if (step) begin
      case (mode_q)
        PK_FOUR: sr_n = sr_q >> LANE4_W;
        PK_TWO:  sr_n = sr_q >> LANE2_W;
        default: sr_n = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      msk_q  <= '0;
      mode_q <= PK_ONE;
    end else if (reg_en) begin
      sr_q   <= sr_n;
      msk_q  <= msk_n;
      mode_q <= mode_n;
    end
  end

  // The mask is always narrower than the active lane, so it also isolates lane 0.
  assign tx_data = sr_q & msk_q;

endmodule

// File: rtl/pwb_rx_pack.sv
module pwb_rx_pack
  import pwb_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [BUS_W-1:0]    start_mask,
  input  pk_mode_e            start_mode,
  input  logic                pop,
  input  logic [PK_IDX_W-1:0] idx,
  input  logic [BUS_W-1:0]    rx_data,
  output logic [BUS_W-1:0]    acc
);

  localparam int NG     = PK_MAX_WORDS;
  localparam int GRAN_W = BUS_W / NG;

  logic [BUS_W-1:0] acc_q, acc_n;
  logic [BUS_W-1:0] msk_q;
  pk_mode_e         mode_q;
  logic [BUS_W-1:0] masked;
  logic [BUS_W-1:0] place;
  logic [NG-1:0]    hit;
  logic             acc_en;

  assign masked = rx_data & msk_q;

  for (genvar g = 0; g < NG; g++) begin : g_gran
    always_comb begin
      case (mode_q)
        PK_FOUR: begin
          hit[g] = (idx == PK_IDX_W'(g));
          place[g*GRAN_W +: GRAN_W] = masked[GRAN_W-1:0];
        end
        PK_TWO: begin
          hit[g] = (idx == PK_IDX_W'(g / 2));
          place[g*GRAN_W +: GRAN_W] = masked[(g % 2)*GRAN_W +: GRAN_W];
        end
        default: begin
          hit[g] = 1'b1;
          place[g*GRAN_W +: GRAN_W] = masked[g*GRAN_W +: GRAN_W];
        end
      endcase
    end
    always_comb begin
      if (start)
        acc_n[g*GRAN_W +: GRAN_W] = '0;
      else if (hit[g])
        acc_n[g*GRAN_W +: GRAN_W] = place[g*GRAN_W +: GRAN_W];
      else
        acc_n[g*GRAN_W +: GRAN_W] = acc_q[g*GRAN_W +: GRAN_W];
    end
  end

  assign acc_en = start | pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
    end else if (acc_en) begin
      acc_q  <= acc_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msk_q  <= '0;
      mode_q <= PK_ONE;
    end else if (start) begin
      msk_q  <= start_mask;
      mode_q <= start_mode;
    end
  end

  assign acc = acc_q;

endmodule

// File: rtl/pwb_sticky.sv
module pwb_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);

  logic flag_q, flag_n;

  assign flag_n = set | (flag_q & ~clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_n;
  end

  assign flag = flag_q;

endmodule

// File: rtl/packed_word_bridge.sv
module packed_word_bridge
  import pwb_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int WL_W   = 5,
  parameter int WCNT_W = 16,
  parameter int LVL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_pack_en,
  input  logic              cfg_fifo_en,
  input  logic [WL_W-1:0]   cfg_wlen,
  input  logic [1:0]        cfg_ae_low2,
  input  logic [1:0]        cfg_af_low2,
  input  logic [WCNT_W-1:0] cfg_wcount,
  input  logic              err_clr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_full,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  output logic              busy,
  output logic              err_pulse,
  output logic              err_sticky,
  input  logic [LVL_W-1:0]  tx_space,
  output logic              tx_push,
  output logic [BUS_W-1:0]  tx_data,
  input  logic [LVL_W-1:0]  rx_count,
  output logic              rx_pop,
  input  logic [BUS_W-1:0]  rx_data
);

  pk_mode_e         mode;
  logic             pack_on;
  logic             cfg_fault;
  logic [BUS_W-1:0] len_mask;

  pwb_cfg_decode #(
    .BUS_W (BUS_W),
    .WL_W  (WL_W),
    .WCNT_W(WCNT_W)
  ) u_dec (
    .pack_en  (cfg_pack_en),
    .fifo_en  (cfg_fifo_en),
    .wlen     (cfg_wlen),
    .ae_low2  (cfg_ae_low2),
    .af_low2  (cfg_af_low2),
    .wcount   (cfg_wcount),
    .mode     (mode),
    .pack_on  (pack_on),
    .cfg_fault(cfg_fault),
    .len_mask (len_mask)
  );

  // Sequencer
  sq_state_e           st_q, st_n;
  logic [PK_IDX_W-1:0] idx_q, idx_n;
  logic [PK_IDX_W-1:0] last_q, last_n;
  logic                seq_en;
  logic                req;
  logic                req_wr;
  logic [2:0]          n_words;
  logic                cfg_refuse;
  logic                room_ok;
  logic                go;
  logic                refuse;
  logic                at_last;
  logic                rvalid_q, rvalid_n;
  logic                errp_q;

  assign req        = (bus_wr | bus_rd) & (st_q == SQ_IDLE);
  assign req_wr     = bus_wr;
  assign n_words    = pk_words(mode);
  assign cfg_refuse = pack_on & (~bus_full | ~cfg_fifo_en);
  assign room_ok    = req_wr ? (tx_space >= LVL_W'(n_words))
                             : (rx_count >= LVL_W'(n_words));
  assign go         = req & ~cfg_refuse & room_ok;
  assign refuse     = req & ~go;
  assign at_last    = (idx_q == last_q);

  always_comb begin
    st_n   = st_q;
    idx_n  = idx_q;
    last_n = last_q;
    case (st_q)
      SQ_IDLE: begin
        if (go) begin
          st_n   = req_wr ? SQ_WR : SQ_RD;
          idx_n  = '0;
          last_n = PK_IDX_W'(n_words - 3'd1);
        end
      end
      SQ_WR, SQ_RD: begin
        idx_n = idx_q + 1'b1;
        if (at_last) st_n = SQ_IDLE;
      end
      default: st_n = SQ_IDLE;
    endcase
  end

  assign seq_en   = go | (st_q != SQ_IDLE);
  assign rvalid_n = (st_q == SQ_RD) & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      idx_q  <= '0;
      last_q <= '0;
    end else if (seq_en) begin
      st_q   <= st_n;
      idx_q  <= idx_n;
      last_q <= last_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      errp_q   <= 1'b0;
    end else begin
      rvalid_q <= rvalid_n;
      errp_q   <= refuse;
    end
  end

  assign tx_push    = (st_q == SQ_WR);
  assign rx_pop     = (st_q == SQ_RD);
  assign busy       = (st_q != SQ_IDLE);
  assign bus_rvalid = rvalid_q;
  assign err_pulse  = errp_q;

  pwb_tx_unpack #(.BUS_W(BUS_W)) u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (go & req_wr),
    .ld_data(bus_wdata),
    .ld_mask(len_mask),
    .ld_mode(mode),
    .step   (tx_push),
    .tx_data(tx_data)
  );

  pwb_rx_pack #(.BUS_W(BUS_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (go & ~req_wr),
    .start_mask(len_mask),
    .start_mode(mode),
    .pop       (rx_pop),
    .idx       (idx_q),
    .rx_data   (rx_data),
    .acc       (bus_rdata)
  );

  logic sticky_set;
  assign sticky_set = cfg_fault | (req & pack_on & ~bus_full);

  pwb_sticky u_sticky (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (sticky_set),
    .clr  (err_clr),
    .flag (err_sticky)
  );

endmodule

// File: rtl/packed_word_bridge_chk.sv
module packed_word_bridge_chk
  import pwb_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic tx_push,
  input logic rx_pop,
  input logic bus_rvalid,
  input logic err_pulse,
  input logic err_sticky,
  input logic err_clr
);

  logic [2:0] burst_q, burst_n;

  assign burst_n = busy ? burst_q + {2'b00, (tx_push | rx_pop)} : 3'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) burst_q <= 3'd0;
    else        burst_q <= burst_n;
  end

  // R1: no burst moves more words than the largest packing factor
  a_r1_burst_max: assert property (@(posedge clk) disable iff (!rst_n)
    burst_q <= 3'(PK_MAX_WORDS));

  // R5: transfers happen only inside a busy window
  a_r5_push_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> busy);

  a_r5_pop_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> busy);

  a_r5_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_push && rx_pop));

  // R5: read data valid only right after the final pop
  a_r5_rvalid_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> ($past(rx_pop) && !busy));

  // R6: a refused access starts no burst
  a_r6_refusal_no_burst: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> !busy);

  // R10: the sticky flag only drops on a clear strobe
  a_r10_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sticky && !err_clr) |=> err_sticky);

endmodule

bind packed_word_bridge packed_word_bridge_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .tx_push   (tx_push),
  .rx_pop    (rx_pop),
  .bus_rvalid(bus_rvalid),
  .err_pulse (err_pulse),
  .err_sticky(err_sticky),
  .err_clr   (err_clr)
);

// File: tb/packed_word_bridge_test.sv
module packed_word_bridge_test;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        cfg_pack_en;
  logic        cfg_fifo_en;
  logic [4:0]  cfg_wlen;
  logic [1:0]  cfg_ae_low2;
  logic [1:0]  cfg_af_low2;
  logic [15:0] cfg_wcount;
  logic        err_clr;
  logic        bus_wr;
  logic        bus_rd;
  logic        bus_full;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        busy;
  logic        err_pulse;
  logic        err_sticky;
  logic [3:0]  tx_space;
  logic        tx_push;
  logic [31:0] tx_data;
  logic [3:0]  rx_count;
  logic        rx_pop;
  logic [31:0] rx_data;

  packed_word_bridge uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_pack_en(cfg_pack_en), .cfg_fifo_en(cfg_fifo_en), .cfg_wlen(cfg_wlen),
    .cfg_ae_low2(cfg_ae_low2), .cfg_af_low2(cfg_af_low2), .cfg_wcount(cfg_wcount),
    .err_clr(err_clr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_full(bus_full),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .busy(busy), .err_pulse(err_pulse), .err_sticky(err_sticky),
    .tx_space(tx_space), .tx_push(tx_push), .tx_data(tx_data),
    .rx_count(rx_count), .rx_pop(rx_pop), .rx_data(rx_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Receive FIFO model and transfer monitors
  int          rx_head  = 0;
  bit          pop_prev = 0;
  logic [31:0] cap [0:4095];
  int          cap_n   = 0;
  int          err_cnt = 0;
  int          pop_cnt = 0;
  int          rv_cnt  = 0;
  logic [31:0] rv_data = '0;

  function automatic logic [31:0] gen(input int i);
    gen = (32'(i) * 32'h9E37_79B1) ^ 32'hC3A5_5A3C;
  endfunction

  assign rx_data = gen(rx_head);

  always @(negedge clk) begin
    if (pop_prev) rx_head = rx_head + 1;
    pop_prev = rx_pop;
    if (tx_push) begin
      cap[cap_n % 4096] = tx_data;
      cap_n = cap_n + 1;
    end
    if (err_pulse) err_cnt = err_cnt + 1;
    if (rx_pop) pop_cnt = pop_cnt + 1;
    if (bus_rvalid) begin
      rv_cnt  = rv_cnt + 1;
      rv_data = bus_rdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int exp_n(input logic pe, input logic [4:0] code);
    if (pe && code <= 5'd6)       exp_n = 4;
    else if (pe && code <= 5'd14) exp_n = 2;
    else                          exp_n = 1;
  endfunction

  function automatic logic [31:0] wmask(input logic [4:0] code);
    if (code == 5'd31) wmask = '1;
    else               wmask = (32'h1 << (int'(code) + 1)) - 32'h1;
  endfunction

  task automatic do_access(input bit wr, input bit full, input logic [31:0] wd,
                           input bit poke);
    int n, w, b_cap, b_err, b_pop, b_rv, h0;
    bit packing, cfg_bad, ok;
    logic [31:0] m, e;
    bit busy_v [0:5];
    string dtag;
    n       = exp_n(cfg_pack_en, cfg_wlen);
    packing = cfg_pack_en && (cfg_wlen <= 5'd14);
    cfg_bad = packing && (!full || !cfg_fifo_en);
    ok      = !cfg_bad && (wr ? (int'(tx_space) >= n) : (int'(rx_count) >= n));
    w       = 32 / n;
    m       = wmask(cfg_wlen);
    dtag    = (n == 4) ? "R2" : (n == 2) ? "R3" : "R4";

    @(negedge clk); #1;
    b_cap = cap_n; b_err = err_cnt; b_pop = pop_cnt; b_rv = rv_cnt; h0 = rx_head;
    bus_wr = wr; bus_rd = !wr; bus_full = full; bus_wdata = wd;
    @(negedge clk); #1;
    bus_wr = 1'b0; bus_rd = 1'b0;
    busy_v[0] = busy;
    if (poke) begin
      bus_wr = 1'b1; bus_full = 1'b1; bus_wdata = ~wd;
    end
    for (int k = 1; k < 6; k++) begin
      @(negedge clk); #1;
      bus_wr = 1'b0;
      busy_v[k] = busy;
    end

    for (int k = 0; k < 6; k++)
      chk(busy_v[k] == (ok && k < n), "R5 busy window", 32'(busy_v[k]), 32'(ok && k < n));

    if (!ok) begin
      chk(err_cnt - b_err == 1, cfg_bad ? "R8 refusal" : (wr ? "R6 refusal" : "R7 refusal"),
          32'(err_cnt - b_err), 32'd1);
      chk(cap_n == b_cap && pop_cnt == b_pop, "R6 R7 R8 no transfer",
          32'(cap_n - b_cap + pop_cnt - b_pop), 32'd0);
    end else begin
      chk(err_cnt == b_err, "R6 R7 no error on accepted", 32'(err_cnt - b_err), 32'd0);
      if (wr) begin
        chk(cap_n - b_cap == n && pop_cnt == b_pop, poke ? "R11 count" : "R1 count",
            32'(cap_n - b_cap), 32'(n));
        for (int k = 0; k < n; k++) begin
          e = (wd >> (k * w)) & m;
          chk(cap[(b_cap + k) % 4096] == e, poke ? "R11 data" : dtag,
              cap[(b_cap + k) % 4096], e);
        end
      end else begin
        chk(pop_cnt - b_pop == n && cap_n == b_cap, "R1 count", 32'(pop_cnt - b_pop), 32'(n));
        chk(rv_cnt - b_rv == 1, "R5 rvalid", 32'(rv_cnt - b_rv), 32'd1);
        e = '0;
        for (int k = 0; k < n; k++) e = e | ((gen(h0 + k) & m) << (k * w));
        chk(rv_data == e, dtag, rv_data, e);
      end
    end
  endtask

  task automatic wait_cyc(input int c);
    for (int k = 0; k < c; k++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk); #1; err_clr = 1'b1;
    @(negedge clk); #1; err_clr = 1'b0;
  endtask

  task automatic legal_cfg(input logic pe, input logic [4:0] code);
    cfg_pack_en = pe; cfg_fifo_en = 1'b1; cfg_wlen = code;
    cfg_ae_low2 = 2'b11; cfg_af_low2 = 2'b11; cfg_wcount = 16'h0;
  endtask

  initial begin
    void'($urandom(32'd7081));
    rst_n = 1'b0; err_clr = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_full = 1'b1;
    bus_wdata = '0; tx_space = 4'd8; rx_count = 4'd8;
    legal_cfg(1'b0, 5'd7);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R12 reset state
    chk(busy == 1'b0, "R12 busy", 32'(busy), 32'd0);
    chk(tx_push == 1'b0, "R12 tx_push", 32'(tx_push), 32'd0);
    chk(rx_pop == 1'b0, "R12 rx_pop", 32'(rx_pop), 32'd0);
    chk(bus_rvalid == 1'b0, "R12 rvalid", 32'(bus_rvalid), 32'd0);
    chk(err_sticky == 1'b0, "R12 sticky", 32'(err_sticky), 32'd0);
    chk(err_pulse == 1'b0, "R12 err_pulse", 32'(err_pulse), 32'd0);
    chk(bus_rdata == 32'h0, "R12 rdata", bus_rdata, 32'h0);

    // R2 4-word lanes with upper bits dropped
    legal_cfg(1'b1, 5'd6);
    do_access(1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0);
    do_access(1'b1, 1'b1, 32'h8C5A_3F01, 1'b0);
    do_access(1'b0, 1'b1, 32'h0, 1'b0);
    legal_cfg(1'b1, 5'd2);
    do_access(1'b0, 1'b1, 32'h0, 1'b0);
    // R3 2-word lanes
    legal_cfg(1'b1, 5'd7);
    do_access(1'b1, 1'b1, 32'h1234_ABCD, 1'b0);
    legal_cfg(1'b1, 5'd14);
    do_access(1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0);
    do_access(1'b0, 1'b1, 32'h0, 1'b0);
    // R1 R4 one word when packing does not apply
    legal_cfg(1'b1, 5'd15);
    do_access(1'b1, 1'b1, 32'h1234_ABCD, 1'b0);
    do_access(1'b1, 1'b0, 32'h5555_AAAA, 1'b0);
    legal_cfg(1'b0, 5'd31);
    do_access(1'b1, 1'b0, 32'hDEAD_BEEF, 1'b0);
    do_access(1'b0, 1'b1, 32'h0, 1'b0);
    legal_cfg(1'b0, 5'd3);
    do_access(1'b0, 1'b1, 32'h0, 1'b0);

    // R6 R7 occupancy one below the factor
    legal_cfg(1'b1, 5'd4);
    tx_space = 4'd3;
    do_access(1'b1, 1'b1, 32'h0102_0304, 1'b0);
    tx_space = 4'd4;
    do_access(1'b1, 1'b1, 32'h0102_0304, 1'b0);
    legal_cfg(1'b1, 5'd9);
    rx_count = 4'd1;
    do_access(1'b0, 1'b1, 32'h0, 1'b0);
    rx_count = 4'd2;
    do_access(1'b0, 1'b1, 32'h0, 1'b0);
    tx_space = 4'd8; rx_count = 4'd8;

    // R11 request during a burst
    legal_cfg(1'b1, 5'd3);
    do_access(1'b1, 1'b1, 32'h0F1E_2D3C, 1'b1);

    // R8 narrow access and FIFO disabled
    wait_cyc(2);
    chk(err_sticky == 1'b0, "R9 legal config keeps sticky clear", 32'(err_sticky), 32'd0);
    do_access(1'b1, 1'b0, 32'h1111_2222, 1'b0);
    chk(err_sticky == 1'b1, "R8 narrow sets sticky", 32'(err_sticky), 32'd1);
    pulse_clr();
    wait_cyc(1);
    chk(err_sticky == 1'b0, "R10 clear", 32'(err_sticky), 32'd0);
    cfg_fifo_en = 1'b0;
    do_access(1'b0, 1'b1, 32'h0, 1'b0);
    chk(err_sticky == 1'b1, "R8 fifo off sets sticky", 32'(err_sticky), 32'd1);
    // R10 set wins over clear while fault persists
    pulse_clr();
    wait_cyc(1);
    chk(err_sticky == 1'b1, "R10 set wins", 32'(err_sticky), 32'd1);
    cfg_fifo_en = 1'b1;
    wait_cyc(1);
    chk(err_sticky == 1'b1, "R10 holds after fault gone", 32'(err_sticky), 32'd1);
    pulse_clr();
    wait_cyc(1);
    chk(err_sticky == 1'b0, "R10 cleared", 32'(err_sticky), 32'd0);

    // R9 threshold alignment and word count
    cfg_ae_low2 = 2'b10;
    wait_cyc(2);
    chk(err_sticky == 1'b1, "R9 almost-empty misaligned", 32'(err_sticky), 32'd1);
    cfg_ae_low2 = 2'b11; pulse_clr(); wait_cyc(1);
    cfg_af_low2 = 2'b01;
    wait_cyc(2);
    chk(err_sticky == 1'b1, "R9 almost-full misaligned", 32'(err_sticky), 32'd1);
    cfg_af_low2 = 2'b11; pulse_clr(); wait_cyc(1);
    cfg_wcount = 16'h0002;
    wait_cyc(2);
    chk(err_sticky == 1'b1, "R9 count bit1 in 4-word", 32'(err_sticky), 32'd1);
    legal_cfg(1'b1, 5'd10); cfg_wcount = 16'h0002; pulse_clr(); wait_cyc(2);
    chk(err_sticky == 1'b0, "R9 count ok in 2-word", 32'(err_sticky), 32'd0);
    cfg_wcount = 16'h0003;
    wait_cyc(2);
    chk(err_sticky == 1'b1, "R9 count bit0 in 2-word", 32'(err_sticky), 32'd1);
    legal_cfg(1'b1, 5'd20); cfg_ae_low2 = 2'b00; cfg_wcount = 16'h0001; pulse_clr(); wait_cyc(2);
    chk(err_sticky == 1'b0, "R1 no packing no fault", 32'(err_sticky), 32'd0);

    // Random mix
    for (int it = 0; it < 400; it++) begin
      legal_cfg(1'($urandom_range(0, 1)), 5'($urandom_range(0, 31)));
      tx_space = 4'($urandom_range(0, 6));
      rx_count = 4'($urandom_range(0, 6));
      do_access(1'($urandom_range(0, 1)), ($urandom_range(0, 7) != 0), $urandom(), 1'b0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule